// File: doc/BRIEF.md
# Copy-DMA Link Control and Status Register Bank

This block is the software-facing register bank of a two-direction copy DMA engine. The engine moves data out of memory on the transmit side and back into memory on the receive side, and each direction follows its own chain of linked descriptors. Software uses simple single-cycle register writes to give each direction the address of its first descriptor. It also uses those writes to issue stop, start and restart-from-last-address commands. Each command reaches the descriptor state machine as a pulse that lasts one clock cycle. Software reads back whether each state machine is idle.

The bank follows descriptor progress. When the engine reports that it has moved to a new descriptor in either direction, the bank keeps the current descriptor address and the two before it. At end-of-frame events it captures descriptor addresses: the transmit EOF descriptor, the transmit descriptor before it, and the receive descriptor on a good EOF. Nine engine events set sticky interrupt bits. Each bit can be enabled and can be cleared by writing a one, and together the bits drive one interrupt line. A configuration byte drives the engine's reset and owner-handling controls, and a fixed version word sits at the top of the 256-byte window.

Reads are combinational: `reg_rdata_o` always returns the word at `reg_addr_i`. Writes take effect at the clock edge where `reg_wr_i` is high.

Top module: `cdma_regfile`

## Requirements
- R1: After reset, the raw, masked and enable interrupt words read 0, as do the configuration word (0x18), the captured addresses and the history words. `irq_o` is 0. No command pulse is active.
- R2: Offset 0xFC reads 0x18082000, and writes to it have no effect.
- R3: Link control is at 0x10 for transmit and 0x14 for receive. Bits [19:0] are stored, driven on the direction's link-address output and read back. Write bits 28 (stop), 29 (start) and 30 (restart) appear on command output bits [0], [1] and [2] for exactly the one cycle after the write. After that the command bits read 0.
- R4: Bit 31 of a link control word reads the direction's idle input (1 = idle), and writes to bit 31 are ignored.
- R5: An event input bit k sets raw interrupt bit k (offset 0x00) at the next edge, and the bit stays set. The bit order is: 0 rx done, 1 rx good EOF, 2 tx done, 3 tx EOF, 4 rx descriptor error, 5 tx descriptor error, 6 rx descriptors exhausted, 7 tx all sent, 8 checksum done.
- R6: Writing 1s to offset 0x0C clears the matching raw bits, and 0x0C reads 0. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Offset 0x08 holds a 9-bit enable. Offset 0x04 reads raw AND enable, and `irq_o` is 1 exactly when that word is non-zero.
- R8: A new-descriptor pulse loads the supplied address into current (tx 0x30, rx 0x40). In the same edge, the old current moves to previous (0x34/0x44) and the old previous moves to second-previous (0x38/0x48).
- R9: Event bit 3 copies the tx current address into 0x20 and the tx previous address into 0x28. Event bit 1 copies the rx current address into 0x24. In each case the value taken is the one from before any history shift in the same edge.
- R10: Offset 0x18 holds 8 writable bits that drive `cfg_o`. Bit 0 enables the owner check, 1 enables tx write-back, 2 is the tx owner value, 3 the rx owner value, 4 resets the rx state machine, 5 the tx state machine, 6 the command FIFOs and 7 the rx data FIFO. Bits 31:8 read 0.
- R11: Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| evt_i | input | 9 | Engine event pulses, one per interrupt bit |
| irq_o | output | 1 | Combined interrupt |
| tx_idle_i | input | 1 | Transmit descriptor machine idle |
| rx_idle_i | input | 1 | Receive descriptor machine idle |
| tx_dscr_new_i | input | 1 | Transmit moved to a new descriptor |
| tx_dscr_addr_i | input | 32 | Address of that transmit descriptor |
| rx_dscr_new_i | input | 1 | Receive moved to a new descriptor |
| rx_dscr_addr_i | input | 32 | Address of that receive descriptor |
| tx_link_addr_o | output | 20 | Transmit first-descriptor address |
| tx_cmd_o | output | 3 | Transmit command pulses {restart, start, stop} |
| rx_link_addr_o | output | 20 | Receive first-descriptor address |
| rx_cmd_o | output | 3 | Receive command pulses {restart, start, stop} |
| cfg_o | output | 8 | Configuration bits |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, an engine event raises a raw bit at the same edge where software writes a one to clear that bit. In the second pair, an EOF event captures a descriptor address at the same edge where a new-descriptor pulse shifts the history. The random phase drives events, clear writes, enable writes and descriptor pulses together on every iteration, and a directed case forces an event and a clear onto the same bit. A bench model judges the results: in it the event beats the clear, and the capture takes the history as it stood before the shift.

// File: rtl/cdma_reg_pkg.sv
package cdma_reg_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int N_IRQ   = 9;
  localparam int LINK_AW = 20;
  localparam int CFG_W   = 8;
  localparam int N_DIR   = 2;   // 0 = transmit, 1 = receive

  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MSK   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ENA   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_TXLNK = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RXLNK = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TXEOF = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RXEOF = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_TXBFR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_TXCUR = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_TXPRV = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_TXPR2 = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_RXCUR = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_RXPRV = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_RXPR2 = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_VER   = 8'hFC;

  localparam logic [DATA_W-1:0] VERSION_WORD = 32'h1808_2000;

  localparam int IRQ_RX_EOF = 1;
  localparam int IRQ_TX_EOF = 3;

  typedef struct packed {
    logic restart;
    logic start;
    logic stop;
  } lnk_cmd_t;
endpackage

// File: rtl/cdma_link_ctl.sv
module cdma_link_ctl
  import cdma_reg_pkg::*;
#(
  parameter int AW_L = LINK_AW,
  parameter int DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr_i,
  input  logic [AW_L-1:0] addr_wd_i,
  input  lnk_cmd_t        cmd_wd_i,
  input  logic            idle_i,
  input  logic            new_i,
  input  logic [DW-1:0]   daddr_i,
  output logic [AW_L-1:0] link_addr_o,
  output lnk_cmd_t        cmd_o,
  output logic [DW-1:0]   ctl_rd_o,
  output logic [DW-1:0]   cur_o,
  output logic [DW-1:0]   prev_o,
  output logic [DW-1:0]   prev2_o
);
  localparam int PAD_W = DW - 4 - AW_L;

  logic [AW_L-1:0] addr_q, addr_d;
  lnk_cmd_t        cmd_q, cmd_d;
  logic [DW-1:0]   cur_q, prv_q, pr2_q;

  always_comb begin
    addr_d = addr_q;
    cmd_d  = '0;
    if (ctl_wr_i) begin
      addr_d = addr_wd_i;
      cmd_d  = cmd_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cmd_q  <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      prv_q <= '0;
      pr2_q <= '0;
    end else if (new_i) begin
      cur_q <= daddr_i;
      prv_q <= cur_q;
      pr2_q <= prv_q;
    end
  end

  assign link_addr_o = addr_q;
  assign cmd_o       = cmd_q;
  assign ctl_rd_o    = {idle_i, cmd_q, {PAD_W{1'b0}}, addr_q};
  assign cur_o       = cur_q;
  assign prev_o      = prv_q;
  assign prev2_o     = pr2_q;
endmodule

// File: rtl/cdma_irq_bank.sv
module cdma_irq_bank
  import cdma_reg_pkg::*;
#(
  parameter int N = N_IRQ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_wr_i,
  input  logic         ena_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] ena_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, raw_d, ena_q, ena_d, clr_m;

  always_comb begin
    clr_m = clr_wr_i ? wdata_i : '0;
    raw_d = (raw_q & ~clr_m) | evt_i;   // event beats clear
    ena_d = ena_wr_i ? wdata_i : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      ena_q <= '0;
    end else begin
      raw_q <= raw_d;
      ena_q <= ena_d;
    end
  end

  assign raw_o = raw_q;
  assign ena_o = ena_q;
  assign irq_o = |(raw_q & ena_q);
endmodule

// File: rtl/cdma_eof_cap.sv
module cdma_eof_cap
  import cdma_reg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_eof_i,
  input  logic          rx_eof_i,
  input  logic [DW-1:0] tx_cur_i,
  input  logic [DW-1:0] tx_prev_i,
  input  logic [DW-1:0] rx_cur_i,
  output logic [DW-1:0] tx_eof_o,
  output logic [DW-1:0] tx_bfr_o,
  output logic [DW-1:0] rx_eof_o
);
  logic [DW-1:0] txe_q, txb_q, rxe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= '0;
      txb_q <= '0;
    end else if (tx_eof_i) begin
      txe_q <= tx_cur_i;
      txb_q <= tx_prev_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rxe_q <= '0;
    else if (rx_eof_i) rxe_q <= rx_cur_i;
  end

  assign tx_eof_o = txe_q;
  assign tx_bfr_o = txb_q;
  assign rx_eof_o = rxe_q;
endmodule

// File: rtl/cdma_regfile.sv
module cdma_regfile
  import cdma_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [N_IRQ-1:0]   evt_i,
  output logic               irq_o,
  input  logic               tx_idle_i,
  input  logic               rx_idle_i,
  input  logic               tx_dscr_new_i,
  input  logic [DATA_W-1:0]  tx_dscr_addr_i,
  input  logic               rx_dscr_new_i,
  input  logic [DATA_W-1:0]  rx_dscr_addr_i,
  output logic [LINK_AW-1:0] tx_link_addr_o,
  output logic [2:0]         tx_cmd_o,
  output logic [LINK_AW-1:0] rx_link_addr_o,
  output logic [2:0]         rx_cmd_o,
  output logic [CFG_W-1:0]   cfg_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31], reg_wdata_i[27:20]};

  // per-direction link control
  logic [N_DIR-1:0]                 lnk_wr, idle_v, new_v;
  logic [N_DIR-1:0][DATA_W-1:0]     daddr_v, ctl_rd, hist_cur, hist_prev, hist_prev2;
  logic [N_DIR-1:0][LINK_AW-1:0]    link_addr;
  lnk_cmd_t [N_DIR-1:0]             cmd_w;

  assign lnk_wr  = {reg_wr_i && (reg_addr_i == OFS_RXLNK), reg_wr_i && (reg_addr_i == OFS_TXLNK)};
  assign idle_v  = {rx_idle_i, tx_idle_i};
  assign new_v   = {rx_dscr_new_i, tx_dscr_new_i};
  assign daddr_v = {rx_dscr_addr_i, tx_dscr_addr_i};

  for (genvar gi = 0; gi < N_DIR; gi++) begin : g_dir
    cdma_link_ctl #(.AW_L(LINK_AW), .DW(DATA_W)) u_link (
      .clk         (clk),
      .rst_n       (rst_ns),
      .ctl_wr_i    (lnk_wr[gi]),
      .addr_wd_i   (reg_wdata_i[LINK_AW-1:0]),
      .cmd_wd_i    (reg_wdata_i[30:28]),
      .idle_i      (idle_v[gi]),
      .new_i       (new_v[gi]),
      .daddr_i     (daddr_v[gi]),
      .link_addr_o (link_addr[gi]),
      .cmd_o       (cmd_w[gi]),
      .ctl_rd_o    (ctl_rd[gi]),
      .cur_o       (hist_cur[gi]),
      .prev_o      (hist_prev[gi]),
      .prev2_o     (hist_prev2[gi])
    );
  end

  assign tx_link_addr_o = link_addr[0];
  assign rx_link_addr_o = link_addr[1];
  assign tx_cmd_o       = cmd_w[0];
  assign rx_cmd_o       = cmd_w[1];

  // interrupts
  logic [N_IRQ-1:0] irq_raw, irq_ena;
  cdma_irq_bank #(.N(N_IRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_ns),
    .evt_i    (evt_i),
    .clr_wr_i (reg_wr_i && (reg_addr_i == OFS_CLR)),
    .ena_wr_i (reg_wr_i && (reg_addr_i == OFS_ENA)),
    .wdata_i  (reg_wdata_i[N_IRQ-1:0]),
    .raw_o    (irq_raw),
    .ena_o    (irq_ena),
    .irq_o    (irq_o)
  );

  // EOF address capture
  logic [DATA_W-1:0] tx_eof_addr, tx_bfr_addr, rx_eof_addr;
  cdma_eof_cap #(.DW(DATA_W)) u_eof (
    .clk       (clk),
    .rst_n     (rst_ns),
    .tx_eof_i  (evt_i[IRQ_TX_EOF]),
    .rx_eof_i  (evt_i[IRQ_RX_EOF]),
    .tx_cur_i  (hist_cur[0]),
    .tx_prev_i (hist_prev[0]),
    .rx_cur_i  (hist_cur[1]),
    .tx_eof_o  (tx_eof_addr),
    .tx_bfr_o  (tx_bfr_addr),
    .rx_eof_o  (rx_eof_addr)
  );

  // configuration byte
  logic [CFG_W-1:0] cfg_q, cfg_d;
  always_comb begin
    cfg_d = cfg_q;
    if (reg_wr_i && (reg_addr_i == OFS_CFG)) cfg_d = reg_wdata_i[CFG_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end
  assign cfg_o = cfg_q;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_RAW:   reg_rdata_o[N_IRQ-1:0] = irq_raw;
      OFS_MSK:   reg_rdata_o[N_IRQ-1:0] = irq_raw & irq_ena;
      OFS_ENA:   reg_rdata_o[N_IRQ-1:0] = irq_ena;
      OFS_TXLNK: reg_rdata_o = ctl_rd[0];
      OFS_RXLNK: reg_rdata_o = ctl_rd[1];
      OFS_CFG:   reg_rdata_o[CFG_W-1:0] = cfg_q;
      OFS_TXEOF: reg_rdata_o = tx_eof_addr;
      OFS_RXEOF: reg_rdata_o = rx_eof_addr;
      OFS_TXBFR: reg_rdata_o = tx_bfr_addr;
      OFS_TXCUR: reg_rdata_o = hist_cur[0];
      OFS_TXPRV: reg_rdata_o = hist_prev[0];
      OFS_TXPR2: reg_rdata_o = hist_prev2[0];
      OFS_RXCUR: reg_rdata_o = hist_cur[1];
      OFS_RXPRV: reg_rdata_o = hist_prev[1];
      OFS_RXPR2: reg_rdata_o = hist_prev2[1];
      OFS_VER:   reg_rdata_o = VERSION_WORD;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cdma_regfile_chk.sv
module cdma_regfile_chk
  import cdma_reg_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [N_IRQ-1:0]  evt_i,
  input logic [N_IRQ-1:0]  irq_raw,
  input logic              irq_o,
  input logic [2:0]        tx_cmd_o,
  input logic              tx_dscr_new_i,
  input logic [DATA_W-1:0] tx_cur,
  input logic [DATA_W-1:0] tx_prev,
  input logic [DATA_W-1:0] tx_eof_addr
);
  // R3: a transmit start write yields a start pulse on the next cycle
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr_i && reg_addr_i == OFS_TXLNK && reg_wdata_i[29]) |=> tx_cmd_o[1]);

  // R3: no command pulse without a write to the control word one cycle before
  a_r3_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_cmd_o != 3'b000) |-> $past(reg_wr_i && reg_addr_i == OFS_TXLNK));

  // R5: every event bit is set in the raw word after the edge
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    (evt_i != '0) |=> ((irq_raw & $past(evt_i)) == $past(evt_i)));

  // R6: cleared bits without a concurrent event are zero afterwards
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr_i && reg_addr_i == OFS_CLR) |=>
      ((irq_raw & $past(reg_wdata_i[N_IRQ-1:0] & ~evt_i)) == '0));

  // R7: the interrupt line only rises after an event or an enable write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(irq_o) |-> $past((evt_i != '0) || (reg_wr_i && reg_addr_i == OFS_ENA)));

  // R8: history shift moves current into previous
  a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_dscr_new_i |=> (tx_prev == $past(tx_cur)));

  // R9: transmit EOF captures the pre-shift current address
  a_r9_tx_eof_cap: assert property (@(posedge clk) disable iff (!rst_ns)
    evt_i[IRQ_TX_EOF] |=> (tx_eof_addr == $past(tx_cur)));
endmodule

bind cdma_regfile cdma_regfile_chk u_chk (
  .clk           (clk),
  .rst_ns        (rst_ns),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .evt_i         (evt_i),
  .irq_raw       (irq_raw),
  .irq_o         (irq_o),
  .tx_cmd_o      (tx_cmd_o),
  .tx_dscr_new_i (tx_dscr_new_i),
  .tx_cur        (hist_cur[0]),
  .tx_prev       (hist_prev[0]),
  .tx_eof_addr   (tx_eof_addr)
);

// File: tb/cdma_regfile_tb.sv
module cdma_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, rdata;
  logic [8:0]  evt;
  logic        irq;
  logic        tx_idle, rx_idle, tx_new, rx_new;
  logic [31:0] tx_daddr, rx_daddr;
  logic [19:0] tx_laddr, rx_laddr;
  logic [2:0]  tx_cmd, rx_cmd;
  logic [7:0]  cfg;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cdma_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq),
    .tx_idle_i(tx_idle), .rx_idle_i(rx_idle), .tx_dscr_new_i(tx_new),
    .tx_dscr_addr_i(tx_daddr), .rx_dscr_new_i(rx_new), .rx_dscr_addr_i(rx_daddr),
    .tx_link_addr_o(tx_laddr), .tx_cmd_o(tx_cmd), .rx_link_addr_o(rx_laddr),
    .rx_cmd_o(rx_cmd), .cfg_o(cfg)
  );

  // bench model
  logic [8:0]  raw_m, ena_m;
  logic [31:0] cur_m [2], prv_m [2], pr2_m [2];
  logic [31:0] txeof_m, txbfr_m, rxeof_m;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic void model_step(input logic [8:0] e, input logic clr, input logic ena,
                                     input logic [31:0] wd, input logic [1:0] nw,
                                     input logic [31:0] a0, input logic [31:0] a1);
    raw_m = (raw_m & ~(clr ? wd[8:0] : 9'h0)) | e;
    if (ena) ena_m = wd[8:0];
    if (e[3]) begin txeof_m = cur_m[0]; txbfr_m = prv_m[0]; end
    if (e[1]) rxeof_m = cur_m[1];
    for (int k = 0; k < 2; k++) begin
      if (nw[k]) begin
        pr2_m[k] = prv_m[k];
        prv_m[k] = cur_m[k];
        cur_m[k] = (k == 0) ? a0 : a1;
      end
    end
  endfunction

  task automatic hist_chk(input string req);
    rd_chk(req, 8'h30, cur_m[0]); rd_chk(req, 8'h34, prv_m[0]); rd_chk(req, 8'h38, pr2_m[0]);
    rd_chk(req, 8'h40, cur_m[1]); rd_chk(req, 8'h44, prv_m[1]); rd_chk(req, 8'h48, pr2_m[1]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, d;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt = '0;
    tx_idle = 1'b1; rx_idle = 1'b0; tx_new = 1'b0; rx_new = 1'b0;
    tx_daddr = '0; rx_daddr = '0;
    raw_m = '0; ena_m = '0; txeof_m = '0; txbfr_m = '0; rxeof_m = '0;
    for (int k = 0; k < 2; k++) begin cur_m[k] = '0; prv_m[k] = '0; pr2_m[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1", 8'h00, 32'h0); rd_chk("R1", 8'h08, 32'h0); rd_chk("R1", 8'h18, 32'h0);
    rd_chk("R1", 8'h20, 32'h0); rd_chk("R1", 8'h24, 32'h0); rd_chk("R1", 8'h28, 32'h0);
    hist_chk("R1");
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 cmd", {26'h0, rx_cmd, tx_cmd}, 32'h0);
    // R4 park flag reflects idle input after reset
    rd_chk("R4", 8'h10, 32'h8000_0000); rd_chk("R4", 8'h14, 32'h0);

    // R2 version, read only
    rd_chk("R2", 8'hFC, 32'h1808_2000);
    wr(8'hFC, 32'h0);
    rd_chk("R2", 8'hFC, 32'h1808_2000);

    // R11 unmapped and write-only offsets
    rd_chk("R11", 8'h1C, 32'h0); rd_chk("R11", 8'h80, 32'h0); rd_chk("R6 clr reads 0", 8'h0C, 32'h0);

    // R3 start pulse on transmit
    wr(8'h10, 32'h2000_0000 | 32'hABCDE);
    chk("R3 tx start", {29'h0, tx_cmd}, 32'h2);
    chk("R3 rx quiet", {29'h0, rx_cmd}, 32'h0);
    chk("R3 link addr", {12'h0, tx_laddr}, 32'hABCDE);
    @(negedge clk);
    chk("R3 self clear", {29'h0, tx_cmd}, 32'h0);
    rd_chk("R3", 8'h10, 32'h800A_BCDE);
    // R4 bit31 write ignored, restart pulse
    wr(8'h10, 32'hC001_2345);
    chk("R3 tx restart", {29'h0, tx_cmd}, 32'h4);
    tx_idle = 1'b0;
    @(negedge clk);
    rd_chk("R4 bit31", 8'h10, 32'h0001_2345);
    wr(8'h14, 32'h1000_0005);
    chk("R3 rx stop", {29'h0, rx_cmd}, 32'h1);
    chk("R3 rx addr", {12'h0, rx_laddr}, 32'h5);
    rx_idle = 1'b1;
    @(negedge clk);
    rd_chk("R4 rx", 8'h14, 32'h8000_0005);

    // R10 configuration
    wr(8'h18, 32'hFFFF_FFA5);
    chk("R10 cfg_o", {24'h0, cfg}, 32'hA5);
    rd_chk("R10", 8'h18, 32'hA5);

    // R5 / R7 directed
    @(negedge clk); evt = 9'h008;
    @(negedge clk); evt = 9'h000; model_step(9'h008, 0, 0, 0, 2'b00, 0, 0);
    rd_chk("R5", 8'h00, 32'h8);
    chk("R7 masked off", {31'h0, irq}, 32'h0);
    wr(8'h08, 32'h0000_0008); model_step(0, 0, 1, 32'h8, 2'b00, 0, 0);
    chk("R7 irq", {31'h0, irq}, 32'h1);
    rd_chk("R7", 8'h04, 32'h8);
    // R6 event and clear on the same bit in the same cycle: event wins
    @(negedge clk); evt = 9'h008; reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h8;
    @(negedge clk); evt = 9'h000; reg_wr = 1'b0;
    rd_chk("R6 event wins", 8'h00, 32'h8);
    wr(8'h0C, 32'h8); model_step(0, 1, 0, 32'h8, 2'b00, 0, 0);
    rd_chk("R6 cleared", 8'h00, 32'h0);
    chk("R6 irq drop", {31'h0, irq}, 32'h0);

    // R8 directed history
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tx_new = 1'b1; rx_new = 1'b1;
      tx_daddr = 32'h1000 + 32'(i); rx_daddr = 32'h2000 + 32'(i);
      @(negedge clk); tx_new = 1'b0; rx_new = 1'b0;
      model_step(0, 0, 0, 0, 2'b11, 32'h1000 + 32'(i), 32'h2000 + 32'(i));
    end
    rd_chk("R8 cur", 8'h30, 32'h1002); rd_chk("R8 prev", 8'h34, 32'h1001);
    rd_chk("R8 prev2", 8'h38, 32'h1000); rd_chk("R8 rx prev2", 8'h48, 32'h2000);

    // R9 directed: EOF capture with a same-edge shift
    @(negedge clk); evt = 9'h00A; tx_new = 1'b1; tx_daddr = 32'h1003;
    @(negedge clk); evt = 9'h000; tx_new = 1'b0;
    model_step(9'h00A, 0, 0, 0, 2'b01, 32'h1003, 0);
    rd_chk("R9 tx eof", 8'h20, 32'h1002); rd_chk("R9 tx bfr", 8'h28, 32'h1001);
    rd_chk("R9 rx eof", 8'h24, 32'h2002);

    // random phase: R5 R6 R7 R8 R9
    for (int it = 0; it < 300; it++) begin
      logic [8:0]  e;
      logic [31:0] wd, a0, a1;
      logic [1:0]  nw;
      logic        c, en;
      int          op;
      @(negedge clk);
      e  = 9'($urandom) & 9'($urandom);
      op = int'($urandom % 4);
      c  = (op == 0); en = (op == 1);
      wd = $urandom; a0 = $urandom; a1 = $urandom; nw = 2'($urandom);
      evt = e; tx_new = nw[0]; rx_new = nw[1]; tx_daddr = a0; rx_daddr = a1;
      reg_wr = c | en; reg_addr = c ? 8'h0C : 8'h08; reg_wdata = wd;
      @(negedge clk);
      evt = '0; tx_new = 1'b0; rx_new = 1'b0; reg_wr = 1'b0;
      model_step(e, c, en, wd, nw, a0, a1);
      rd_chk("R5 R6 raw", 8'h00, {23'h0, raw_m});
      rd_chk("R7 masked", 8'h04, {23'h0, raw_m & ena_m});
      chk("R7 irq", {31'h0, irq}, {31'h0, |(raw_m & ena_m)});
      if (it % 10 == 0) begin
        hist_chk("R8");
        rd_chk("R9", 8'h20, txeof_m); rd_chk("R9", 8'h28, txbfr_m); rd_chk("R9", 8'h24, rxeof_m);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule